// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two bidirectional data buses, A and B. Each direction has a capture register with its own strobe and a select that chooses, per direction, between live data from the opposite bus and the value last captured. Two control inputs set on their own whether side A drives, side B drives, both drive or neither drives.

Each bus is a split interface: an input vector carrying the external driver's value, a flag saying that an external driver is present, an output vector and an output enable. The block holds its own view of each bus. That view is the external value while an external driver is present. Otherwise it is the last value seen on the bus, which includes the value the block drives itself. With both sides driving live data and no external driver on either bus, each output keeps the other bus alive, so both buses keep their last values.

The capture strobes are sampled by one system clock. A register loads on the first clock edge at which its strobe is seen high after being seen low.

Top module: `regd_bus_xcvr`

## Requirements
- R1: While `rst_n` is low, `a_oe` and `b_oe` are 0 and both outputs read 0. Both capture registers and both bus keepers reset to 0, so stored selects show 0 after reset.
- R2: Outside reset, `a_oe` is 1 exactly when `a_drive_n` is 0, and `b_oe` is 1 exactly when `b_drive_en` is 1. All four combinations of the two controls are valid.
- R3: The A-to-B register loads the resolved A value on the first clock edge at which `ab_cap` is 1 while it was 0 at the previous edge. The B-to-A register does the same with `ba_cap` and the resolved B value.
- R4: A capture happens whatever the enables and selects are, including with both outputs disabled. Holding a strobe high does not load the register again.
- R5: When `b_oe` is 1, `b_out` equals the resolved A value unchanged if `b_src_reg` is 0, and the A-to-B register if `b_src_reg` is 1.
- R6: When `a_oe` is 1, `a_out` equals the resolved B value unchanged if `a_src_reg` is 0, and the B-to-A register if `a_src_reg` is 1.
- R7: A disabled output reads 0.
- R8: When a register is captured from one bus and drives the other bus in the same configuration, the driven output shows the old contents before the capture edge and the new contents after it.
- R9: Suppose both sides drive live data, both buses carry the same value and no external driver is present. Both outputs then stay at that value on every later cycle while the configuration holds.
- R10: A bus's resolved value is its input vector while its external-valid flag is 1. Otherwise it is the bus's last value: the block's own output if it drives that bus, or else the value held from before. The input vector is ignored while the flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_in | input | W | Value from the external driver of bus A |
| a_ext_vld | input | 1 | An external driver is active on bus A |
| a_out | output | W | Value driven onto bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_in | input | W | Value from the external driver of bus B |
| b_ext_vld | input | 1 | An external driver is active on bus B |
| b_out | output | W | Value driven onto bus B |
| b_oe | output | 1 | Drive enable for bus B |
| ab_cap | input | 1 | Capture strobe of the A-to-B register (sampled) |
| ba_cap | input | 1 | Capture strobe of the B-to-A register (sampled) |
| b_drive_en | input | 1 | 1: side B drives |
| a_drive_n | input | 1 | 0: side A drives |
| b_src_reg | input | 1 | 0: B gets live A, 1: B gets the A-to-B register |
| a_src_reg | input | 1 | 0: A gets live B, 1: A gets the B-to-A register |

## Verification
The bench walks all sixteen settings of the two enables and two selects with known register contents. A swapped decode, a select inverted or an output left undriven when disabled shows up there as a wrong value or enable. A capture is made with both outputs disabled, which catches a design that gates loading on the enables. A held strobe checks that the register loads on an edge and not on a level. Capture and drive are done in one configuration, which catches an output that changes a cycle early or a cycle late. The live loop is checked after its external driver is released. A design that does not feed its own outputs back into the bus view would lose the value there or show the input vector, which is ignored at that point.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
   typedef enum logic {
      SRC_LIVE   = 1'b0,
      SRC_STORED = 1'b1
   } src_sel_e;
endpackage

// File: rtl/xcvr_edge_cap.sv
module xcvr_edge_cap #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         strobe,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic strobe_q;
   logic load;

   assign load = strobe & ~strobe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe_q <= 1'b0;
         q        <= '0;
      end else begin
         strobe_q <= strobe;
         if (load) q <= d;
      end
   end

   // R3: the register takes the bus value on a detected rising edge
   p_load_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && !strobe_q) |=> (q == $past(d)));
   // R4: a level held high gives no further load
   p_no_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && strobe_q) |=> $stable(q));
endmodule

// File: rtl/xcvr_bus_keeper.sv
module xcvr_bus_keeper #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ext_vld,
   input  logic [W-1:0] ext_data,
   input  logic         own_oe,
   input  logic [W-1:0] own_data,
   output logic [W-1:0] seen
);
   logic [W-1:0] last;

   assign seen = ext_vld ? ext_data : last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       last <= '0;
      else if (ext_vld) last <= ext_data;
      else if (own_oe)  last <= own_data;
   end

   // R10: an undriven bus keeps its value
   p_keep_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_vld && !own_oe) |=> (!ext_vld -> seen == $past(seen)));
endmodule

// File: rtl/xcvr_out_mux.sv
module xcvr_out_mux
   import xcvr_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         en,
   input  src_sel_e     sel,
   input  logic [W-1:0] live,
   input  logic [W-1:0] stored,
   output logic [W-1:0] dout,
   output logic         oe
);
   always_comb begin
      oe = en;
      if (!en)                    dout = '0;
      else if (sel == SRC_STORED) dout = stored;
      else                        dout = live;
   end
endmodule

// File: rtl/regd_bus_xcvr.sv
module regd_bus_xcvr
   import xcvr_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] a_in,
   input  logic         a_ext_vld,
   output logic [W-1:0] a_out,
   output logic         a_oe,
   input  logic [W-1:0] b_in,
   input  logic         b_ext_vld,
   output logic [W-1:0] b_out,
   output logic         b_oe,
   input  logic         ab_cap,
   input  logic         ba_cap,
   input  logic         b_drive_en,
   input  logic         a_drive_n,
   input  logic         b_src_reg,
   input  logic         a_src_reg
);
   localparam int MSB = W - 1;

   generate
      if (W < 1) begin : g_bad_width
         $error("regd_bus_xcvr: W must be at least 1");
      end
   endgenerate

   logic [MSB:0] a_seen, b_seen;
   logic [MSB:0] ab_q, ba_q;
   logic         a_en, b_en;

   assign a_en = rst_n & ~a_drive_n;
   assign b_en = rst_n & b_drive_en;

   xcvr_bus_keeper #(.W(W)) a_keep_i (
      .clk(clk), .rst_n(rst_n), .ext_vld(a_ext_vld), .ext_data(a_in),
      .own_oe(a_oe), .own_data(a_out), .seen(a_seen));

   xcvr_bus_keeper #(.W(W)) b_keep_i (
      .clk(clk), .rst_n(rst_n), .ext_vld(b_ext_vld), .ext_data(b_in),
      .own_oe(b_oe), .own_data(b_out), .seen(b_seen));

   xcvr_edge_cap #(.W(W)) ab_reg_i (
      .clk(clk), .rst_n(rst_n), .strobe(ab_cap), .d(a_seen), .q(ab_q));

   xcvr_edge_cap #(.W(W)) ba_reg_i (
      .clk(clk), .rst_n(rst_n), .strobe(ba_cap), .d(b_seen), .q(ba_q));

   xcvr_out_mux #(.W(W)) b_mux_i (
      .en(b_en), .sel(src_sel_e'(b_src_reg)), .live(a_seen), .stored(ab_q),
      .dout(b_out), .oe(b_oe));

   xcvr_out_mux #(.W(W)) a_mux_i (
      .en(a_en), .sel(src_sel_e'(a_src_reg)), .live(b_seen), .stored(ba_q),
      .dout(a_out), .oe(a_oe));

   // R1: quiet outputs while reset is held
   always_comb begin
      if (!rst_n) begin
         p_reset_quiet_r1: assert (!a_oe && !b_oe && a_out == '0 && b_out == '0);
      end
   end

   // R5: live A reaches B unchanged
   p_live_to_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (b_oe && !b_src_reg && a_ext_vld) |-> (b_out == a_in));
   // R6: live B reaches A unchanged
   p_live_to_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (a_oe && !a_src_reg && b_ext_vld) |-> (a_out == b_in));

   logic loop_on;
   assign loop_on = a_oe && b_oe && !a_src_reg && !b_src_reg && !a_ext_vld && !b_ext_vld;

   // R9: a settled loop holds both buses
   p_loop_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_on && $past(loop_on) && $past(a_out == b_out)) |->
      (a_out == b_out && $stable(a_out)));
endmodule

// File: tb/regd_bus_xcvr_tb_top.sv
module regd_bus_xcvr_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] a_in = '0, b_in = '0;
   logic       a_ext_vld = 1'b0, b_ext_vld = 1'b0;
   logic [7:0] a_out, b_out;
   logic       a_oe, b_oe;
   logic       ab_cap = 1'b0, ba_cap = 1'b0;
   logic       b_drive_en = 1'b0, a_drive_n = 1'b1;
   logic       b_src_reg = 1'b0, a_src_reg = 1'b0;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   regd_bus_xcvr #(.W(8)) dut_i (
      .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_ext_vld(a_ext_vld),
      .a_out(a_out), .a_oe(a_oe), .b_in(b_in), .b_ext_vld(b_ext_vld),
      .b_out(b_out), .b_oe(b_oe), .ab_cap(ab_cap), .ba_cap(ba_cap),
      .b_drive_en(b_drive_en), .a_drive_n(a_drive_n),
      .b_src_reg(b_src_reg), .a_src_reg(a_src_reg));

   // {b_drive_en, a_drive_n, b_src_reg, a_src_reg, a_oe, a_out, b_oe, b_out}
   // AB reg = 3C, BA reg = A5, a_in = 5A, b_in = C3
   localparam logic [21:0] VEC [16] = '{
      {4'h0, 1'b1, 8'hC3, 1'b0, 8'h00},
      {4'h1, 1'b1, 8'hA5, 1'b0, 8'h00},
      {4'h2, 1'b1, 8'hC3, 1'b0, 8'h00},
      {4'h3, 1'b1, 8'hA5, 1'b0, 8'h00},
      {4'h4, 1'b0, 8'h00, 1'b0, 8'h00},
      {4'h5, 1'b0, 8'h00, 1'b0, 8'h00},
      {4'h6, 1'b0, 8'h00, 1'b0, 8'h00},
      {4'h7, 1'b0, 8'h00, 1'b0, 8'h00},
      {4'h8, 1'b1, 8'hC3, 1'b1, 8'h5A},
      {4'h9, 1'b1, 8'hA5, 1'b1, 8'h5A},
      {4'hA, 1'b1, 8'hC3, 1'b1, 8'h3C},
      {4'hB, 1'b1, 8'hA5, 1'b1, 8'h3C},
      {4'hC, 1'b0, 8'h00, 1'b1, 8'h5A},
      {4'hD, 1'b0, 8'h00, 1'b1, 8'h5A},
      {4'hE, 1'b0, 8'h00, 1'b1, 8'h3C},
      {4'hF, 1'b0, 8'h00, 1'b1, 8'h3C}
   };

   task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic set_ctl(input logic [3:0] c);
      {b_drive_en, a_drive_n, b_src_reg, a_src_reg} = c;
   endtask

   task automatic pulse_ab();
      ab_cap = 1'b1; tick(); ab_cap = 1'b0; tick();
   endtask

   task automatic pulse_ba();
      ba_cap = 1'b1; tick(); ba_cap = 1'b0; tick();
   endtask

   initial begin
      #(8 * 20000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // R1: reset with both sides requested to drive
      set_ctl(4'hB);
      a_ext_vld = 1'b1; b_ext_vld = 1'b1; a_in = 8'h5A; b_in = 8'hC3;
      tick(); tick();
      check("R1 a_oe in reset", {1'b0, 7'd0, a_oe}, 9'd0);
      check("R1 b_oe in reset", {1'b0, 7'd0, b_oe}, 9'd0);
      check("R1 outputs in reset", {1'b0, a_out | b_out}, 9'd0);
      rst_n = 1'b1;
      tick();
      check("R1 stored B after reset", {b_oe, b_out}, {1'b1, 8'h00});
      check("R1 stored A after reset", {a_oe, a_out}, {1'b1, 8'h00});

      // R4: capture with both outputs disabled
      set_ctl(4'h4);
      a_in = 8'h3C; pulse_ab();
      b_in = 8'hA5; pulse_ba();
      check("R4 disabled during capture", {a_oe, b_oe, 7'd0}, 9'd0);
      a_in = 8'h5A; b_in = 8'hC3;

      // R2 R5 R6 R7: all sixteen control settings
      for (int i = 0; i < 16; i++) begin
         set_ctl(VEC[i][21:18]);
         #2;
         check($sformatf("R2 R6 R7 vec %0d side A", i), {a_oe, a_out}, VEC[i][17:9]);
         check($sformatf("R2 R5 R7 vec %0d side B", i), {b_oe, b_out}, VEC[i][8:0]);
      end

      // R4: strobe held high does not reload
      set_ctl(4'hA);
      a_in = 8'h11; ab_cap = 1'b1; tick();
      check("R3 load on edge", {1'b0, b_out}, {1'b0, 8'h11});
      a_in = 8'h22; tick(); tick();
      check("R4 held strobe no reload", {1'b0, b_out}, {1'b0, 8'h11});
      ab_cap = 1'b0; tick();

      // R8: capture and drive from the same register
      a_in = 8'h77; ab_cap = 1'b1; #2;
      check("R8 old value before edge", {1'b0, b_out}, {1'b0, 8'h11});
      tick();
      check("R8 new value after edge", {1'b0, b_out}, {1'b0, 8'h77});
      ab_cap = 1'b0; tick();

      // R3: B-to-A capture while A shows stored
      set_ctl(4'h1);
      b_in = 8'h4D; ba_cap = 1'b1; tick(); ba_cap = 1'b0;
      check("R3 B-to-A load", {a_oe, a_out}, {1'b1, 8'h4D});

      // R9 R10: bus hold loop
      set_ctl(4'h8);
      a_in = 8'h96; a_ext_vld = 1'b1; b_ext_vld = 1'b0; b_in = 8'hFF;
      tick(); tick();
      check("R10 B input ignored, A follows B bus", {a_oe, a_out}, {1'b1, 8'h96});
      a_ext_vld = 1'b0; a_in = 8'h01;
      tick(); tick(); tick();
      check("R9 loop holds B", {b_oe, b_out}, {1'b1, 8'h96});
      check("R9 loop holds A", {a_oe, a_out}, {1'b1, 8'h96});
      check("R10 A input ignored without driver", {1'b0, b_out}, {1'b0, 8'h96});

      // R10: kept value captured from an undriven bus
      set_ctl(4'h4);
      tick(); pulse_ab();
      set_ctl(4'hA); #2;
      check("R10 capture of kept value", {1'b0, b_out}, {1'b0, 8'h96});

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule